// File: doc/BRIEF.md
# Multi-Stage Sample Trigger

This block watches a stream of wide samples and decides when capture begins. It has a bank of trigger stages. Each stage holds a mask, a compare value and a configuration word. A stage compares either the whole sample, one bit per channel, or the recent history of a single channel, one bit per past sample. A shared trigger level chooses which stages may compare: only stages whose configured level equals the current level take part. When a stage matches, its action fires after an optional delay counted in samples. Firing raises the level by one. If the stage also carries the start flag, firing emits a one-cycle capture-start pulse and disarms the trigger.

Software loads the stages through a simple write port that selects a stage and a register. It then pulses `run`, which clears the level and arms the trigger. Samples enter on a valid/ready interface. `smp_ready` is always high, because the trigger never applies back-pressure. A sample is consumed on every clock edge where `smp_valid` is high.

Top module: `sample_trigger`

## Requirements
- R1: After reset `armed`, `level` and `cap_start` are all 0.
- R2: A `run` pulse sets `armed` to 1 and `level` to 0 on the following cycle.
- R3: In parallel mode, a stage matches a sample when ((sample XOR value) AND mask) is zero.
- R4: In serial mode, mask and value bit i refer to the selected channel's bit i samples back. Bit 0 is the sample being accepted now. Other channels have no influence.
- R5: A stage only compares when the trigger is armed and the current level equals the stage's configured level.
- R6: With delay 0, the stage fires on the matching sample, and `cap_start`/`level` change in the cycle after the edge that accepts it.
- R7: With delay d>0, the stage fires on the d-th accepted sample after the match. Cycles with `smp_valid` low do not count toward d.
- R8: Firing increments `level` whether or not the start flag is set. A stage without the start flag never drives `cap_start`.
- R9: Firing a start-flagged stage pulses `cap_start` for exactly one cycle and clears `armed`.
- R10: When several eligible stages match on the same sample, only the lowest-numbered stage acts.
- R11: `cfg_sel` encodes 0 = mask, 1 = value, 2 = config, and 3 is ignored. The config word holds delay in [15:0], level in [17:16], channel in [24:20], serial in [27] and start in [31].
- R12: `smp_ready` is constantly 1. Samples accepted while disarmed leave `level` and `cap_start` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; disarms the trigger |
| run | input | 1 | Arm pulse; clears the level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 2 | Stage selected for the write |
| cfg_sel | input | 2 | Register selected: 0 mask, 1 value, 2 config |
| cfg_wdata | input | 32 | Write data |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_data | input | 32 | Sample, one bit per channel |
| armed | output | 1 | Trigger armed |
| level | output | 2 | Current trigger level |
| cap_start | output | 1 | One-cycle capture start pulse |

## Verification
The bench builds the block with its defaults: four stages, 32-bit samples and a 16-bit delay. This size is enough to run a two-level sequence, to test priority between stage 0 and stage 2, and to use a serial trigger on channel 5. It also reaches a delayed fire whose countdown spans idle cycles. A short delay of 3 exercises the counter's terminal step without long runs. The defaults also let the unused stages be parked at level 3, which the tests never reach.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CFG_DLY_LSB = 0;
  localparam int CFG_LVL_LSB = 16;
  localparam int CFG_CH_LSB  = 20;
  localparam int CFG_SER_BIT = 27;
  localparam int CFG_STA_BIT = 31;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CONF  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/trig_stage.sv
module trig_stage
  import trig_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int DELAY_W  = 16,
  parameter int LVL_W    = 2,
  localparam int CH_W    = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic                smp_take,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [LVL_W-1:0]    cur_level,
  input  logic                eval_en,
  output logic                hit,
  output logic [DELAY_W-1:0]  delay_o,
  output logic                start_o
);
  logic [SAMPLE_W-1:0] mask_q, value_q, hist_q, hist_next, word;
  logic [DELAY_W-1:0]  dly_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [CH_W-1:0]     ch_q;
  logic                ser_q, sta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      value_q <= '0;
      dly_q   <= '0;
      lvl_q   <= '0;
      ch_q    <= '0;
      ser_q   <= 1'b0;
      sta_q   <= 1'b0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_MASK:  mask_q  <= wdata;
        SEL_VALUE: value_q <= wdata;
        SEL_CONF: begin
          dly_q <= wdata[CFG_DLY_LSB +: DELAY_W];
          lvl_q <= wdata[CFG_LVL_LSB +: LVL_W];
          ch_q  <= wdata[CFG_CH_LSB +: CH_W];
          ser_q <= wdata[CFG_SER_BIT];
          sta_q <= wdata[CFG_STA_BIT];
        end
        default: ;
      endcase
    end
  end

  assign hist_next = {hist_q[SAMPLE_W-2:0], smp_data[ch_q]};

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (smp_take) hist_q <= hist_next;
  end

  assign word    = ser_q ? hist_next : smp_data;
  assign hit     = eval_en && smp_take && (lvl_q == cur_level) &&
                   (((word ^ value_q) & mask_q) == '0);
  assign delay_o = dly_q;
  assign start_o = sta_q;

  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_take |=> $stable(hist_q));
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
  parameter int NUM_STAGES = 4,
  parameter int DELAY_W    = 16,
  parameter int LVL_W      = 2,
  localparam int IDX_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               smp_take,
  input  logic               hit   [NUM_STAGES],
  input  logic [DELAY_W-1:0] dly   [NUM_STAGES],
  input  logic               start [NUM_STAGES],
  output logic               eval_en,
  output logic [LVL_W-1:0]   level,
  output logic               armed,
  output logic               cap_start
);
  logic               pend_q, pend_start_q;
  logic [DELAY_W-1:0] cnt_q;
  logic [IDX_W-1:0]   win;
  logic               any_hit, fire_now, fire_pend, fire, fire_start;

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        win     = IDX_W'(i);
      end
    end
  end

  assign eval_en    = armed && !pend_q;
  assign fire_now   = any_hit && (dly[win] == '0);
  assign fire_pend  = pend_q && smp_take && (cnt_q == DELAY_W'(1));
  assign fire       = fire_now || fire_pend;
  assign fire_start = fire_pend ? pend_start_q : start[win];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      level        <= '0;
      cap_start    <= 1'b0;
      pend_q       <= 1'b0;
      pend_start_q <= 1'b0;
      cnt_q        <= '0;
    end else if (run) begin
      armed     <= 1'b1;
      level     <= '0;
      cap_start <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      cap_start <= 1'b0;
      if (fire) begin
        if (level != '1) level <= level + 1'b1;
        if (fire_start) begin
          cap_start <= 1'b1;
          armed     <= 1'b0;
        end
      end
      if (any_hit && !fire_now) begin
        pend_q       <= 1'b1;
        cnt_q        <= dly[win];
        pend_start_q <= start[win];
      end else if (fire_pend) begin
        pend_q <= 1'b0;
      end else if (pend_q && smp_take) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start |=> !cap_start);
  p_disarm_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start |-> !armed);
  p_level_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (level == $past(level)) || (level == $past(level) + 1'b1));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !smp_take) |=> ($stable(level) && !cap_start));
  p_run_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (level == '0) && armed);
  p_no_fire_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !run) |=> !cap_start);
endmodule

// File: rtl/sample_trigger.sv
module sample_trigger #(
  parameter int SAMPLE_W   = 32,
  parameter int NUM_STAGES = 4,
  parameter int DELAY_W    = 16,
  localparam int LVL_W     = $clog2(NUM_STAGES),
  localparam int STG_W     = $clog2(NUM_STAGES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                cfg_we,
  input  logic [STG_W-1:0]    cfg_stage,
  input  logic [1:0]          cfg_sel,
  input  logic [SAMPLE_W-1:0] cfg_wdata,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                armed,
  output logic [LVL_W-1:0]    level,
  output logic                cap_start
);
  logic               hit   [NUM_STAGES];
  logic [DELAY_W-1:0] dly   [NUM_STAGES];
  logic               start [NUM_STAGES];
  logic               eval_en;
  logic               smp_take;

  assign smp_ready = 1'b1;
  assign smp_take  = smp_valid && smp_ready;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    trig_stage #(
      .SAMPLE_W (SAMPLE_W),
      .DELAY_W  (DELAY_W),
      .LVL_W    (LVL_W)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we && (cfg_stage == STG_W'(g))),
      .sel       (cfg_sel),
      .wdata     (cfg_wdata),
      .smp_take  (smp_take),
      .smp_data  (smp_data),
      .cur_level (level),
      .eval_en   (eval_en),
      .hit       (hit[g]),
      .delay_o   (dly[g]),
      .start_o   (start[g])
    );
  end

  trig_sequencer #(
    .NUM_STAGES (NUM_STAGES),
    .DELAY_W    (DELAY_W),
    .LVL_W      (LVL_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .smp_take  (smp_take),
    .hit       (hit),
    .dly       (dly),
    .start     (start),
    .eval_en   (eval_en),
    .level     (level),
    .armed     (armed),
    .cap_start (cap_start)
  );
endmodule

// File: tb/tb_sample_trigger.sv
module tb_sample_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_stage = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] smp_data = '0;
  logic        armed;
  logic [1:0]  level;
  logic        cap_start;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sample_trigger dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .armed(armed), .level(level),
    .cap_start(cap_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int lv, input int cs, input int ar);
    chk(level == 2'(lv), {req, " level"}, level, lv);
    chk(cap_start == 1'(cs), {req, " cap_start"}, cap_start, cs);
    chk(armed == 1'(ar), {req, " armed"}, armed, ar);
  endtask

  task automatic wr(input int stg, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stage = 2'(stg); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] conf(input int dly, input int lvl, input int ch,
                                       input bit ser, input bit sta);
    return (32'(dly) & 32'hFFFF) | (32'(lvl) << 16) | (32'(ch) << 20) |
           (32'(ser) << 27) | (32'(sta) << 31);
  endfunction

  task automatic stage(input int stg, input logic [31:0] m, input logic [31:0] v,
                       input logic [31:0] c);
    wr(stg, 0, m); wr(stg, 1, v); wr(stg, 2, c);
  endtask

  task automatic park_all();
    for (int s = 0; s < 4; s++) stage(s, 32'hFFFF_FFFF, 32'hFFFF_FFFF, conf(0, 3, 0, 0, 0));
  endtask

  task automatic do_run();
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_data = d;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1", 0, 0, 0);
    chk(smp_ready == 1'b1, "R12 ready", smp_ready, 1);
  endtask

  task automatic t_parallel();
    park_all();
    stage(0, 32'h0000_FF00, 32'h0000_3400, conf(0, 0, 0, 0, 1));
    do_run();
    expect_out("R2", 0, 0, 1);
    send(32'h0000_1200);
    expect_out("R3 mismatch", 0, 0, 1);
    send(32'hAB00_34CD);
    expect_out("R6 R9 fire", 1, 1, 0);
    @(negedge clk);
    chk(cap_start == 1'b0, "R9 one cycle", cap_start, 0);
    send(32'h0000_3400);
    expect_out("R12 disarmed", 1, 0, 0);
    do_run();
    expect_out("R2 rerun", 0, 0, 1);
  endtask

  task automatic t_levels();
    park_all();
    stage(0, 32'hFF, 32'h11, conf(0, 0, 0, 0, 0));
    stage(1, 32'hFF, 32'h22, conf(0, 1, 0, 0, 1));
    do_run();
    send(32'h22);
    expect_out("R5 gated", 0, 0, 1);
    send(32'h11);
    expect_out("R8 no start", 1, 0, 1);
    send(32'h22);
    expect_out("R5 R8 level1", 2, 1, 0);
  endtask

  task automatic t_delay();
    park_all();
    stage(0, 32'hFF, 32'h55, conf(3, 0, 0, 0, 1));
    do_run();
    send(32'h55);
    expect_out("R7 match", 0, 0, 1);
    repeat (4) @(negedge clk);
    expect_out("R7 idle", 0, 0, 1);
    send(32'h0); send(32'h0);
    expect_out("R7 count2", 0, 0, 1);
    send(32'h0);
    expect_out("R7 fire", 1, 1, 0);
  endtask

  task automatic t_priority();
    park_all();
    stage(0, 32'hF0, 32'hA0, conf(0, 0, 0, 0, 0));
    stage(2, 32'hF0, 32'hA0, conf(0, 0, 0, 0, 1));
    do_run();
    send(32'hA3);
    expect_out("R10 lowest wins", 1, 0, 1);
  endtask

  task automatic t_serial();
    bit seq [8] = '{0, 0, 0, 0, 1, 0, 1, 1};
    park_all();
    stage(1, 32'hF, 32'hB, conf(0, 0, 5, 1, 1));
    do_run();
    for (int i = 0; i < 7; i++) begin
      send((32'(seq[i]) << 5) | (32'(!seq[i]) << 6) | 32'h8000_001F);
      expect_out("R4 pending", 0, 0, 1);
    end
    send((32'(seq[7]) << 5) | 32'h8000_001F);
    expect_out("R4 serial fire", 1, 1, 0);
  endtask

  task automatic t_sel_ignored();
    park_all();
    stage(0, 32'hFF, 32'h77, conf(0, 0, 0, 0, 1));
    wr(0, 3, 32'h0);
    do_run();
    send(32'h77);
    expect_out("R11 sel3 ignored", 1, 1, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parallel();
        t_levels();
        t_delay();
        t_priority();
        t_serial();
        t_sel_ignored();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule